// File: doc/BRIEF.md
# Buzzer PWM Output Driver

This block produces the one-bit level that switches an external transistor feeding a buzzer. The level is a pulse-width-modulated carrier. Its period is set by a 3-bit carrier frequency code, which is the same code that selects the first tone frequency. A 4-bit duty code sets the high time, and the high time is the only volume control. As an option, the carrier can be multiplied by a slower square wave whose rate comes from a second 3-bit code. This gives beep and warble patterns. In the operating mode that has no buzzer, the pin is held low.

Each carrier period is divided into 32 equal slots. A slot lasts `SLOT_BASE + SLOT_STEP*freq` clocks, which is 2 to 9 clocks with the defaults. A three-state machine tracks the period:
- **IDLE**: the output is off.
- **MARK**: the output is high.
- **SPACE**: the output is low for the rest of the period.

The transitions are named as follows:
- *start* (IDLE→MARK) when the block becomes active.
- *mark_done* (MARK→SPACE) at the end of the slot whose index equals the duty code.
- *wrap* (SPACE→MARK) at the end of slot 31.
- *halt* (MARK or SPACE→IDLE) when the block becomes inactive.

The codes are captured only while the machine is in IDLE or at a period boundary.

Top module: `buzzer_pwm_drv`

## Requirements
- R1: While reset is asserted, and after reset while `en_i` is low, `bz_o` is 0.
- R2: With gating off, the carrier period is `32*(SLOT_BASE+SLOT_STEP*freq_i)` clocks. With the defaults this is 64 clocks for code 0 and 288 clocks for code 7.
- R3: Each pulse is high for `(duty_i+1)*(SLOT_BASE+SLOT_STEP*freq_i)` clocks. Duty code 15 gives exactly half the period, and no code gives more.
- R4: With `gate_en_i`=1, a gating square wave is used. It starts high, stays high for `gate_code_i+1` whole carrier periods, and then stays low for the same number of periods. The pattern repeats. In every carrier period where the gating wave is low, `bz_o` stays 0.
- R5: A change of `freq_i`, `duty_i`, `gate_code_i` or `gate_en_i` during a period has no effect on that period. It applies from the next period boundary.
- R6: When `mode_i` equals 3 (the mode without a buzzer) or `en_i` is low, `bz_o` is 0 from the next clock and stays 0.
- R7: When the block becomes active (`en_i` high and `mode_i` not 3), `bz_o` goes high on the next clock. This starts a fresh period, and the gating wave begins in its high phase.
- R8: Modes 0, 1 and 2 produce the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Buzzer enable |
| mode_i | input | 2 | Operating mode; 3 disables the buzzer |
| freq_i | input | 3 | Carrier frequency code (shared with tone 1) |
| gate_code_i | input | 3 | Gating wave frequency code (shared with tone 2) |
| gate_en_i | input | 1 | Multiply carrier by gating wave |
| duty_i | input | 4 | Duty (volume) code |
| bz_o | output | 1 | Buzzer drive level |

## Verification
A wrong internal state shows up at the pin within one carrier period, in one of three ways:
- A corrupted slot counter or tick counter changes the measured rise-to-rise interval.
- A wrong compare in MARK changes the high width.
- Loading the codes at the wrong time leaves the interrupted period with the new width instead of the old one.

A fault in the gating counter shows in the interval that spans the silent periods, which is `(gate_code+2)` periods long. A state machine that does not return to IDLE shows on the first clock after disable or after a switch into mode 3.

// File: rtl/bzr_pkg.sv
package bzr_pkg;

    typedef enum logic [1:0] {
        MODE_VOICE = 2'd0,
        MODE_AUDIO = 2'd1,
        MODE_TONE  = 2'd2,
        MODE_FM    = 2'd3
    } bzr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } bzr_state_e;

endpackage

// File: rtl/bzr_slot_timer.sv
module bzr_slot_timer #(
    parameter int LEN_W  = 4,
    parameter int SLOT_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [LEN_W-1:0]  slot_len_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [LEN_W-1:0]  tick_o,
    output logic              slot_end_o,
    output logic              period_end_o
);

    logic [LEN_W-1:0]  tick_q;
    logic [SLOT_W-1:0] slot_q;

    assign slot_end_o   = run_i && (tick_q == slot_len_i - LEN_W'(1));
    assign period_end_o = slot_end_o && (&slot_q);
    assign slot_o       = slot_q;
    assign tick_o       = tick_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_q <= '0;
            slot_q <= '0;
        end else if (!run_i) begin
            tick_q <= '0;
            slot_q <= '0;
        end else if (slot_end_o) begin
            tick_q <= '0;
            slot_q <= slot_q + SLOT_W'(1);
        end else begin
            tick_q <= tick_q + LEN_W'(1);
        end
    end

endmodule

// File: rtl/bzr_gate_gen.sv
module bzr_gate_gen #(
    parameter int GCODE_W   = 3,
    parameter int GATE_UNIT = 1,
    parameter int GCNT_W    = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               period_end_i,
    input  logic [GCODE_W-1:0] gcode_i,
    output logic               gate_o
);

    logic [GCNT_W-1:0] cnt_q;
    logic [GCNT_W-1:0] half_len;
    logic              lvl_q;

    assign half_len = GCNT_W'((int'(gcode_i) + 1) * GATE_UNIT);
    assign gate_o   = lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (!run_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (period_end_i) begin
            if (cnt_q == half_len - GCNT_W'(1)) begin
                cnt_q <= '0;
                lvl_q <= ~lvl_q;
            end else begin
                cnt_q <= cnt_q + GCNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/buzzer_pwm_drv.sv
module buzzer_pwm_drv #(
    parameter int FREQ_W    = 3,
    parameter int DUTY_W    = 4,
    parameter int GCODE_W   = 3,
    parameter int SLOT_BASE = 2,
    parameter int SLOT_STEP = 1,
    parameter int GATE_UNIT = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [1:0]         mode_i,
    input  logic [FREQ_W-1:0]  freq_i,
    input  logic [GCODE_W-1:0] gate_code_i,
    input  logic               gate_en_i,
    input  logic [DUTY_W-1:0]  duty_i,
    output logic               bz_o
);
    import bzr_pkg::*;

    localparam int SLOT_W  = DUTY_W + 1;
    localparam int MAX_LEN = SLOT_BASE + SLOT_STEP * ((2 ** FREQ_W) - 1);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int GCNT_W  = $clog2((2 ** GCODE_W) * GATE_UNIT + 1);

    bzr_state_e         state_q, state_d;
    logic               active;
    logic               run;
    logic [FREQ_W-1:0]  cfg_freq_q;
    logic [DUTY_W-1:0]  cfg_duty_q;
    logic [GCODE_W-1:0] cfg_gcode_q;
    logic               cfg_gate_en_q;
    logic [LEN_W-1:0]   slot_len;
    logic [SLOT_W-1:0]  slot_idx;
    logic [LEN_W-1:0]   tick_cnt;
    logic               slot_end;
    logic               period_end;
    logic               gate_lvl;

    assign active   = en_i && (mode_i != MODE_FM);
    assign run      = (state_q != ST_IDLE);
    assign slot_len = LEN_W'(SLOT_BASE + SLOT_STEP * int'(cfg_freq_q));

    // settings are captured while idle and at each period boundary only
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_freq_q    <= '0;
            cfg_duty_q    <= '0;
            cfg_gcode_q   <= '0;
            cfg_gate_en_q <= 1'b0;
        end else if (state_q == ST_IDLE || period_end) begin
            cfg_freq_q    <= freq_i;
            cfg_duty_q    <= duty_i;
            cfg_gcode_q   <= gate_code_i;
            cfg_gate_en_q <= gate_en_i;
        end
    end

    bzr_slot_timer #(
        .LEN_W (LEN_W),
        .SLOT_W(SLOT_W)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .slot_len_i  (slot_len),
        .slot_o      (slot_idx),
        .tick_o      (tick_cnt),
        .slot_end_o  (slot_end),
        .period_end_o(period_end)
    );

    bzr_gate_gen #(
        .GCODE_W  (GCODE_W),
        .GATE_UNIT(GATE_UNIT),
        .GCNT_W   (GCNT_W)
    ) u_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .period_end_i(period_end),
        .gcode_i     (cfg_gcode_q),
        .gate_o      (gate_lvl)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active) state_d = ST_MARK;
            end
            ST_MARK: begin
                if (!active)
                    state_d = ST_IDLE;
                else if (slot_end && slot_idx == {1'b0, cfg_duty_q})
                    state_d = ST_SPACE;
            end
            ST_SPACE: begin
                if (!active)          state_d = ST_IDLE;
                else if (period_end)  state_d = ST_MARK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bz_o = (state_q == ST_MARK) && (!cfg_gate_en_q || gate_lvl);
    end

endmodule

// File: rtl/bzr_checker.sv
module bzr_checker #(
    parameter int LEN_W  = 4,
    parameter int SLOT_W = 5,
    parameter int CAP    = 144
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic [1:0]        mode_i,
    input logic              bz_o,
    input logic [SLOT_W-1:0] slot_i,
    input logic [LEN_W-1:0]  tick_i
);
    localparam int CNT_W = $clog2(CAP + 2);

    logic             act;
    logic [CNT_W-1:0] run_q;

    assign act = en_i && (mode_i != bzr_pkg::MODE_FM);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    run_q <= '0;
        else if (!bz_o)                 run_q <= '0;
        else if (run_q != CNT_W'(CAP + 1)) run_q <= run_q + CNT_W'(1);
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act |=> !bz_o);

    // R7
    restart_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(act) |=> bz_o);

    // R3
    duty_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bz_o |-> (run_q < CNT_W'(CAP)));

    // R5
    rise_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bz_o) |-> (slot_i == '0 && tick_i == '0));

endmodule

bind buzzer_pwm_drv bzr_checker #(
    .LEN_W (LEN_W),
    .SLOT_W(SLOT_W),
    .CAP   (MAX_LEN * (2 ** DUTY_W))
) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .mode_i(mode_i),
    .bz_o  (bz_o),
    .slot_i(slot_idx),
    .tick_i(tick_cnt)
);

// File: tb/buzzer_pwm_drv_bench.sv
`timescale 1ns/1ps
module buzzer_pwm_drv_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] freq = 3'd0;
    logic [2:0] gcode = 3'd0;
    logic       gate_en = 1'b0;
    logic [3:0] duty = 4'd0;
    logic       bz;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct { int hi; int per; string tag; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    buzzer_pwm_drv u_buzzer_pwm_drv (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .mode_i     (mode),
        .freq_i     (freq),
        .gate_code_i(gcode),
        .gate_en_i  (gate_en),
        .duty_i     (duty),
        .bz_o       (bz)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input int hi, input int per, input string tag);
        exp_t e;
        e.hi = hi; e.per = per; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_cfg(input logic [2:0] f, input logic [3:0] d,
                           input logic [2:0] g, input logic ge,
                           input logic [1:0] m, input logic e);
        @(negedge clk); #1;
        freq = f; duty = d; gcode = g; gate_en = ge; mode = m; en = e;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_rises(input int n);
        logic p;
        int   seen;
        p = bz;
        seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (bz && !p) seen++;
            p = bz;
        end
    endtask

    // monitor: measures each pulse from rise to next rise and compares
    logic mon_prev = 1'b0;
    bit   armed = 1'b0;
    int   hi_cnt = 0;
    int   per_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!(en && mode != 2'd3)) begin
                armed   = 1'b0;
                hi_cnt  = 0;
                per_cnt = 0;
            end else if (bz && !mon_prev) begin
                if (armed) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected pulse", per_cnt, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(hi_cnt == e.hi, e.tag, "high time", hi_cnt, e.hi);
                        check(per_cnt == e.per, e.tag, "rise interval", per_cnt, e.per);
                    end
                end
                armed   = 1'b1;
                hi_cnt  = 1;
                per_cnt = 1;
            end else begin
                per_cnt++;
                if (bz) hi_cnt++;
            end
            mon_prev = bz;
        end else begin
            mon_prev = 1'b0;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int highs;
        // R1 reset and idle
        repeat (5) @(negedge clk);
        check(bz == 1'b0, "R1", "level in reset", int'(bz), 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bz == 1'b0, "R1", "level while disabled", int'(bz), 0);

        // R2 R3: shortest carrier, minimum duty
        push(2, 64, "R2"); push(2, 64, "R2"); push(2, 64, "R3");
        set_cfg(3'd0, 4'd0, 3'd0, 1'b0, 2'd0, 1'b1);
        drain();
        set_cfg(3'd0, 4'd0, 3'd0, 1'b0, 2'd0, 1'b0);

        // R3 R8: longest carrier, 50 percent, mode 1
        push(144, 288, "R3"); push(144, 288, "R8");
        set_cfg(3'd7, 4'd15, 3'd0, 1'b0, 2'd1, 1'b1);
        drain();
        set_cfg(3'd7, 4'd15, 3'd0, 1'b0, 2'd1, 1'b0);

        // R8 R2: mid code, mode 2
        push(40, 160, "R2"); push(40, 160, "R8");
        set_cfg(3'd3, 4'd7, 3'd0, 1'b0, 2'd2, 1'b1);
        drain();
        set_cfg(3'd3, 4'd7, 3'd0, 1'b0, 2'd2, 1'b0);

        // R5: change codes inside a period
        push(2, 64, "R5"); push(2, 64, "R5");
        set_cfg(3'd0, 4'd0, 3'd0, 1'b0, 2'd0, 1'b1);
        wait_rises(3);
        repeat (5) @(negedge clk);
        #1 freq = 3'd1; duty = 4'd3;
        push(2, 64, "R5");
        push(12, 96, "R5"); push(12, 96, "R5"); push(12, 96, "R5");
        drain();
        set_cfg(3'd1, 4'd3, 3'd0, 1'b0, 2'd0, 1'b0);

        // R4: gating, two periods on, two off
        push(4, 64, "R4"); push(4, 192, "R4"); push(4, 64, "R4"); push(4, 192, "R4");
        set_cfg(3'd0, 4'd1, 3'd1, 1'b1, 2'd0, 1'b1);
        drain();
        set_cfg(3'd0, 4'd1, 3'd1, 1'b1, 2'd0, 1'b0);

        // R4: gating, alternate periods
        push(4, 128, "R4"); push(4, 128, "R4"); push(4, 128, "R4");
        set_cfg(3'd0, 4'd1, 3'd0, 1'b1, 2'd0, 1'b1);
        drain();

        // R7: restart mid pattern starts fresh with gate high
        set_cfg(3'd0, 4'd1, 3'd1, 1'b1, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check(bz == 1'b0, "R6", "level after disable", int'(bz), 0);
        push(4, 64, "R7"); push(4, 192, "R7");
        set_cfg(3'd0, 4'd1, 3'd1, 1'b1, 2'd0, 1'b1);
        @(negedge clk);
        check(bz == 1'b1, "R7", "first cycle after enable", int'(bz), 1);
        drain();

        // R6: mode without buzzer holds the pin low
        set_cfg(3'd0, 4'd15, 3'd0, 1'b0, 2'd3, 1'b1);
        highs = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (bz) highs++;
        end
        check(highs == 0, "R6", "high cycles in mode 3", highs, 0);

        // R6: disabled holds the pin low
        set_cfg(3'd0, 4'd15, 3'd0, 1'b0, 2'd0, 1'b0);
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bz) highs++;
        end
        check(highs == 0, "R6", "high cycles while disabled", highs, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule